// File: doc/BRIEF.md
# Strap-Programmed Clock Divider Chain

This block contains the three integer dividers of a frequency synthesizer whose ratios are set by strap pins. The reference divider divides the incoming reference clock. Its output goes to a phase comparator outside the block. The feedback divider divides the VCO clock for that same comparator. The output divider also divides the VCO clock and drives a pair of output clocks. Either output can feed the rest of the system.

Each divide ratio is a fixed offset added to a strap word, or an entry in a fixed select table. The straps may be tied off on the board. They may also be driven from a parallel port and changed during operation. Each divider first brings its straps into its own clock domain through two flip-flops. It then adopts a new ratio only when its current period ends, so a change never produces a short pulse. Odd ratios use one flop clocked on the rising edge and one on the falling edge, which keeps the duty cycle at half the period.

An active-low asynchronous reset clears all counters and holds every output low. After release, each divider waits for its synchronizer to fill and then starts with a complete first period.

Top module: `strapClkDivChain`

## Requirements
- R1: The reference output period is (refWord + 2) reference-clock periods, for refWord from 0 to 127.
- R2: The feedback output period is (fbWord + 8) VCO periods, for fbWord from 0 to 511.
- R3: The output divider ratio follows outSel (bit 2 is the most significant) through this table: 0→6, 1→2, 2→8, 3→4, 4→5, 5→7, 6→1, 7→3.
- R4: When the selected ratio is 1, clkOutA repeats the VCO clock, with the same period and the same high time.
- R5: For even output ratios, the high time of clkOutA is exactly half its period, which lies inside the 45–55 % window.
- R6: For odd output ratios (3, 5, 7), the high time of clkOutA is exactly half its period, using a falling-edge stage, which lies inside the 40–60 % window.
- R7: When complementMode is 0, clkOutB equals clkOutA at all times.
- R8: When complementMode is 1 and the output divider is running, clkOutB is the inverse of clkOutA.
- R9: While rstN is low, every output is 0. After release, each divider holds its output low until its first period begins, and that first period has full length.
- R10: A strap change made at run time takes effect only at the end of the running period, when the output is low. Every high or low pulse therefore belongs to either the old ratio or the new one.
- R11: All-ones straps, the state of unconnected pull-up pins, give ratios of 129 (reference), 519 (feedback) and 3 (output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low asynchronous reset |
| refClk | input | 1 | Reference clock into the reference divider |
| vcoClk | input | 1 | VCO clock into the feedback and output dividers |
| refWord | input | 7 | Reference strap word; ratio is word + 2 |
| fbWord | input | 9 | Feedback strap word; ratio is word + 8 |
| outSel | input | 3 | Output ratio select code (see R3) |
| complementMode | input | 1 | 0: outputs in phase; 1: outputs complementary |
| refDivClk | output | 1 | Divided reference clock for the phase comparator |
| fbDivClk | output | 1 | Divided VCO clock for the phase comparator |
| clkOutA | output | 1 | Primary output clock |
| clkOutB | output | 1 | Secondary output clock, in phase or inverted |

## Verification
The assertions check on every clock edge that the two outputs keep their mode relationship (R7 and R8). They also check that each divider is low at its terminal count (R10), that the odd-ratio and bypass selections change only at a period boundary, and that no output rises before its divider has started (R9). Exact periods and high times for each strap value (R1–R6 and R11) can only be shown by the bench's scenarios. So can the length of the first pulse after reset and the sequence of pulse widths around a run-time strap change. The bench measures all of these from edge timestamps.

// File: rtl/strapDivPkg.sv
`timescale 1ns/1ps
package strapDivPkg;

  // Strobes from a divider's control to its output datapath
  typedef struct packed {
    logic level;   // next value of the rising-edge output flop
    logic odd;     // active ratio is odd: merge the falling-edge stage
    logic bypass;  // active ratio is 1: pass the input clock through
    logic run;     // divider has started after reset
  } divStrobe_t;

  // Output divider select table (sel[2] is the most significant bit)
  function automatic logic [3:0] outRatioOf(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'd6;
      3'd1:    return 4'd2;
      3'd2:    return 4'd8;
      3'd3:    return 4'd4;
      3'd4:    return 4'd5;
      3'd5:    return 4'd7;
      3'd6:    return 4'd1;
      default: return 4'd3;
    endcase
  endfunction

endpackage

// File: rtl/strapSync.sv
`timescale 1ns/1ps
module strapSync #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ready
);
  logic [W-1:0] metaQ;
  logic [1:0]   fillQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= INIT;
      dout  <= INIT;
      fillQ <= '0;
    end else begin
      metaQ <= din;
      dout  <= metaQ;
      fillQ <= {fillQ[0], 1'b1};
    end
  end

  // High once both stages hold sampled strap values
  assign ready = fillQ[1];
endmodule

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import strapDivPkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ready,
  input  logic [RW-1:0] ratioIn,
  output divStrobe_t    stb,
  output logic          endOfCycle
);
  logic [RW-1:0] cnt, active, cntNext, ratioNext;
  logic          started, loadNow;

  assign endOfCycle = started && (cnt == active - RW'(1));
  // A new ratio is adopted only at the first start or at a period end
  assign loadNow    = !started || endOfCycle;
  assign ratioNext  = loadNow ? ratioIn : active;
  assign cntNext    = loadNow ? '0 : cnt + RW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      active  <= '0;
      started <= 1'b0;
    end else if (ready) begin
      started <= 1'b1;
      cnt     <= cntNext;
      active  <= ratioNext;
    end
  end

  always_comb begin
    stb.level  = ready && (cntNext < (ratioNext >> 1));
    stb.odd    = active[0];
    stb.bypass = (active == RW'(1));
    stb.run    = started;
  end
endmodule

// File: rtl/divData.sv
`timescale 1ns/1ps
module divData
  import strapDivPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t stb,
  output logic       divClk,
  output logic       running
);
  logic posQ, negQ, runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) posQ <= 1'b0;
    else       posQ <= stb.level;
  end

  // Half-cycle delayed copies: stretch odd high phases, and gate bypass cleanly
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      negQ <= 1'b0;
      runQ <= 1'b0;
    end else begin
      negQ <= posQ;
      runQ <= stb.run;
    end
  end

  assign divClk  = stb.bypass ? (clk & runQ) : (stb.odd ? (posQ | negQ) : posQ);
  assign running = runQ;
endmodule

// File: rtl/strapClkDivChain.sv
`timescale 1ns/1ps
module strapClkDivChain
  import strapDivPkg::*;
#(
  parameter int REF_W   = 7,
  parameter int FB_W    = 9,
  parameter int REF_OFS = 2,
  parameter int FB_OFS  = 8
) (
  input  logic             rstN,
  input  logic             refClk,
  input  logic             vcoClk,
  input  logic [REF_W-1:0] refWord,
  input  logic [FB_W-1:0]  fbWord,
  input  logic [2:0]       outSel,
  input  logic             complementMode,
  output logic             refDivClk,
  output logic             fbDivClk,
  output logic             clkOutA,
  output logic             clkOutB
);
  localparam int REF_RW = REF_W + 1;
  localparam int FB_RW  = FB_W + 1;
  localparam int OUT_RW = 4;

  logic [REF_W-1:0]  refWordS;
  logic [FB_W-1:0]   fbWordS;
  logic [2:0]        outSelS;
  logic              refReady, fbReady, outReady;
  logic [REF_RW-1:0] refRatio;
  logic [FB_RW-1:0]  fbRatio;
  logic [OUT_RW-1:0] outRatio;
  divStrobe_t        refStb, fbStb, outStb;
  logic              refTc, fbTc, outTc;
  logic              refRunning, fbRunning, outRunning, outDiv;

  strapSync #(.W(REF_W)) uRefSync (.clk(refClk), .rstN(rstN), .din(refWord), .dout(refWordS), .ready(refReady));
  strapSync #(.W(FB_W))  uFbSync  (.clk(vcoClk), .rstN(rstN), .din(fbWord),  .dout(fbWordS),  .ready(fbReady));
  strapSync #(.W(3))     uOutSync (.clk(vcoClk), .rstN(rstN), .din(outSel),  .dout(outSelS),  .ready(outReady));

  assign refRatio = REF_RW'(refWordS) + REF_RW'(REF_OFS);
  assign fbRatio  = FB_RW'(fbWordS) + FB_RW'(FB_OFS);
  assign outRatio = outRatioOf(outSelS);

  divCtrl #(.RW(REF_RW)) uRefCtrl (.clk(refClk), .rstN(rstN), .ready(refReady), .ratioIn(refRatio), .stb(refStb), .endOfCycle(refTc));
  divCtrl #(.RW(FB_RW))  uFbCtrl  (.clk(vcoClk), .rstN(rstN), .ready(fbReady),  .ratioIn(fbRatio),  .stb(fbStb),  .endOfCycle(fbTc));
  divCtrl #(.RW(OUT_RW)) uOutCtrl (.clk(vcoClk), .rstN(rstN), .ready(outReady), .ratioIn(outRatio), .stb(outStb), .endOfCycle(outTc));

  divData uRefData (.clk(refClk), .rstN(rstN), .stb(refStb), .divClk(refDivClk), .running(refRunning));
  divData uFbData  (.clk(vcoClk), .rstN(rstN), .stb(fbStb),  .divClk(fbDivClk),  .running(fbRunning));
  divData uOutData (.clk(vcoClk), .rstN(rstN), .stb(outStb), .divClk(outDiv),    .running(outRunning));

  assign clkOutA = outDiv;
  assign clkOutB = complementMode ? (~outDiv & outRunning) : outDiv;
endmodule

// File: rtl/divChainChecker.sv
`timescale 1ns/1ps
module divChainChecker (
  input logic refClk,
  input logic vcoClk,
  input logic rstN,
  input logic complementMode,
  input logic refDivClk,
  input logic fbDivClk,
  input logic clkOutA,
  input logic clkOutB,
  input logic refTc,
  input logic refOdd,
  input logic refRun,
  input logic fbTc,
  input logic outTc,
  input logic outOdd,
  input logic outBypass,
  input logic outRun,
  input logic refRunning,
  input logic fbRunning,
  input logic outRunning
);
  AST_REF_IDLE_LOW: assert property (@(posedge refClk) disable iff (!rstN) !refRunning |-> !refDivClk); // R9
  AST_FB_IDLE_LOW: assert property (@(posedge vcoClk) disable iff (!rstN) !fbRunning |-> !fbDivClk); // R9
  AST_OUT_IDLE_LOW: assert property (@(posedge vcoClk) disable iff (!rstN) !outRunning |-> (!clkOutA && !clkOutB)); // R9
  AST_IN_PHASE: assert property (@(posedge vcoClk) disable iff (!rstN) !complementMode |-> (clkOutB == clkOutA)); // R7
  AST_COMPLEMENT: assert property (@(posedge vcoClk) disable iff (!rstN) (complementMode && outRunning) |-> (clkOutB == !clkOutA)); // R8
  AST_REF_END_LOW: assert property (@(posedge refClk) disable iff (!rstN) refTc |-> !refDivClk); // R10
  AST_FB_END_LOW: assert property (@(posedge vcoClk) disable iff (!rstN) fbTc |-> !fbDivClk); // R10
  AST_OUT_END_LOW: assert property (@(posedge vcoClk) disable iff (!rstN) (outTc && !outBypass) |-> !clkOutA); // R10
  AST_OUT_MODE_AT_END: assert property (@(posedge vcoClk) disable iff (!rstN)
    (!$stable(outOdd) || !$stable(outBypass)) |-> ($past(outTc) || !$past(outRun))); // R10
  AST_REF_ODD_AT_END: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(refOdd) |-> ($past(refTc) || !$past(refRun))); // R10
endmodule

bind strapClkDivChain divChainChecker uChk (
  .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .complementMode(complementMode),
  .refDivClk(refDivClk), .fbDivClk(fbDivClk), .clkOutA(clkOutA), .clkOutB(clkOutB),
  .refTc(refTc), .refOdd(refStb.odd), .refRun(refStb.run), .fbTc(fbTc),
  .outTc(outTc), .outOdd(outStb.odd), .outBypass(outStb.bypass), .outRun(outStb.run),
  .refRunning(refRunning), .fbRunning(fbRunning), .outRunning(outRunning)
);

// File: tb/sim_strapClkDivChain.sv
`timescale 1ns/1ps
module sim_strapClkDivChain;
  localparam real REF_T = 8.0;  // 125 MHz
  localparam real VCO_T = 6.0;

  logic refClk = 1'b0, vcoClk = 1'b0, rstN = 1'b0;
  logic [6:0] refWord = '1;
  logic [8:0] fbWord = '1;
  logic [2:0] outSel = '1;
  logic complementMode = 1'b0;
  logic refDivClk, fbDivClk, clkOutA, clkOutB;
  int checks = 0, fails = 0;
  int probeSel = 2;
  logic probe;

  always #4 refClk = ~refClk;
  always #3 vcoClk = ~vcoClk;

  always_comb begin
    case (probeSel)
      0:       probe = refDivClk;
      1:       probe = fbDivClk;
      default: probe = clkOutA;
    endcase
  end

  strapClkDivChain u0 (
    .rstN(rstN), .refClk(refClk), .vcoClk(vcoClk), .refWord(refWord), .fbWord(fbWord),
    .outSel(outSel), .complementMode(complementMode), .refDivClk(refDivClk),
    .fbDivClk(fbDivClk), .clkOutA(clkOutA), .clkOutB(clkOutB)
  );

  function automatic int expOutRatio(input int sel);
    case (sel)
      0: return 6; 1: return 2; 2: return 8; 3: return 4;
      4: return 5; 5: return 7; 6: return 1; default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input string what, input real act, input real exp);
    checks++;
    if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic measure(input int s, output real per, output real hi);
    real t0, t1, t2;
    probeSel = s;
    @(negedge probe);
    @(posedge probe); t0 = $realtime;
    @(negedge probe); t1 = $realtime;
    @(posedge probe); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic settleMeasure(input int s, output real per, output real hi);
    measure(s, per, hi);
    measure(s, per, hi);
  endtask

  task automatic testReset();
    real t0, t1, t2;
    rstN = 1'b0;
    outSel = 3'b011;  // ratio 4
    probeSel = 2;
    repeat (4) @(posedge vcoClk);
    #1;
    check("R9", "outputs during reset", real'({refDivClk, fbDivClk, clkOutA, clkOutB}), 0.0);
    rstN = 1'b1;
    #2;
    check("R9", "outputs just after release", real'({refDivClk, fbDivClk, clkOutA, clkOutB}), 0.0);
    @(posedge probe); t0 = $realtime;
    @(negedge probe); t1 = $realtime;
    @(posedge probe); t2 = $realtime;
    check("R9", "first pulse high time", t1 - t0, 2.0 * VCO_T);
    check("R9", "first period", t2 - t0, 4.0 * VCO_T);
  endtask

  task automatic testRefDivide();
    int words[3] = '{0, 5, 127};
    real per, hi;
    foreach (words[i]) begin
      refWord = 7'(words[i]);
      settleMeasure(0, per, hi);
      check("R1", "reference period", per, real'(words[i] + 2) * REF_T);
    end
  endtask

  task automatic testFbDivide();
    int words[3] = '{0, 100, 511};
    real per, hi;
    foreach (words[i]) begin
      fbWord = 9'(words[i]);
      settleMeasure(1, per, hi);
      check("R2", "feedback period", per, real'(words[i] + 8) * VCO_T);
    end
  endtask

  task automatic testOutTable();
    real per, hi;
    for (int s = 0; s < 8; s++) begin
      int r;
      r = expOutRatio(s);
      outSel = 3'(s);
      settleMeasure(2, per, hi);
      check((r == 1) ? "R4" : "R3", "output period", per, real'(r) * VCO_T);
      check((r == 1) ? "R4" : ((r % 2) == 1 ? "R6" : "R5"), "output high time", hi, real'(r) * VCO_T / 2.0);
    end
  endtask

  task automatic testModes();
    int bad;
    real per, hi;
    outSel = 3'b100;  // ratio 5
    settleMeasure(2, per, hi);
    complementMode = 1'b0;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge vcoClk); #1;
      if (clkOutB !== clkOutA) bad++;
      @(negedge vcoClk); #1;
      if (clkOutB !== clkOutA) bad++;
    end
    check("R7", "in-phase mismatches", real'(bad), 0.0);
    complementMode = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge vcoClk); #1;
      if (clkOutB !== ~clkOutA) bad++;
      @(negedge vcoClk); #1;
      if (clkOutB !== ~clkOutA) bad++;
    end
    check("R8", "complement mismatches", real'(bad), 0.0);
    complementMode = 1'b0;
  endtask

  task automatic testLiveSwitch();
    real per, hi, tr, tn, tr2, hiW, loW;
    int bad;
    outSel = 3'b010;  // ratio 8
    settleMeasure(2, per, hi);
    bad = 0;
    hiW = 0.0;
    @(posedge probe); tr = $realtime;
    fork
      begin #100; outSel = 3'b111; end  // switch to ratio 3
    join_none
    for (int i = 0; i < 24; i++) begin
      @(negedge probe); tn = $realtime;
      @(posedge probe); tr2 = $realtime;
      hiW = tn - tr;
      loW = tr2 - tn;
      if (!((hiW > 23.99 && hiW < 24.01) || (hiW > 8.99 && hiW < 9.01))) bad++;
      if (!((loW > 23.99 && loW < 24.01) || (loW > 8.99 && loW < 9.01))) bad++;
      tr = tr2;
    end
    check("R10", "pulses of neither ratio", real'(bad), 0.0);
    check("R10", "high time after switch", hiW, 9.0);
  endtask

  task automatic testDefaults();
    real per, hi;
    refWord = '1;
    fbWord  = '1;
    outSel  = '1;
    settleMeasure(0, per, hi);
    check("R11", "default reference period", per, 129.0 * REF_T);
    settleMeasure(1, per, hi);
    check("R11", "default feedback period", per, 519.0 * VCO_T);
    settleMeasure(2, per, hi);
    check("R11", "default output period", per, 3.0 * VCO_T);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testRefDivide();
    testFbDivide();
    testOutTable();
    testModes();
    testLiveSwitch();
    testDefaults();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule